// File: doc/BRIEF.md
# I2S Master Serial Transmitter

This block sends audio samples out on a three-wire I2S bus as the bus master. It generates the bit clock, the word select and the serial data from a parallel sample stream that arrives on a valid/ready interface. The bit timing comes from a phase-enable pulse. Each pulse moves the bit machine on by one half bit, so the rate of that pulse fixes the bus rate: the pulse rate must be the sample rate × 2 × slot width × 2.

Two static inputs set the slot width (16 or 32 bits) and the format (mono or stereo). In stereo, the source delivers the left sample and then the right sample, one handshake each. In mono, one sample fills both slots of a frame. When no sample is ready at the moment a slot must start, that slot goes out as zeros. The bus never stalls.

Back-pressure works as follows. `s_ready` is high for exactly one clock, at the moment a slot that can take a new sample begins. A sample transfers when `s_valid` and `s_ready` are both high in the same cycle. The source must hold `s_valid` and `s_data` steady until then. `s_ready` does not depend on `s_valid`.

Top module: `i2s_tx`

## Requirements
- R1: Each `ph_en` pulse toggles `sck`, and `sck` holds its value in cycles without a pulse. One bit period therefore takes two pulses.
- R2: `sd` changes only in the cycle where `sck` falls. It is read on the rising edge, and each slot is sent MSB first.
- R3: With `cfg_wide`=0 a slot is 16 bits wide and carries `s_data[15:0]`. With `cfg_wide`=1 a slot is 32 bits wide and carries `s_data[31:0]`.
- R4: `ws` is 0 during the left slot and 1 during the right slot. It toggles in the same fall of `sck` that drives the LSB of the current slot.
- R5: `s_ready` is high for one cycle only, in a cycle where `ph_en` arrives while `sck` is high and the next bit is the MSB of a slot that can take a sample. A transfer happens on `s_valid && s_ready`.
- R6: With `cfg_mono`=1, samples are taken only at the start of a left slot. The same word is sent in the left slot and again in the right slot, and `s_ready` never rises for a right slot.
- R7: With `cfg_mono`=0, the left sample is taken at the start of the left slot and the right sample at the start of the right slot. A right sample is taken only if the left slot of the same frame took one.
- R8: A slot that starts without a transfer is sent as all zeros. In mono, a left slot without a transfer also makes the following right slot zero.
- R9: During reset, `sck`, `ws`, `sd` and `s_ready` are 0. After reset, the first `ph_en` raises `sck` with `sd`=0 and `ws`=0, and the first slot sent is a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_en | input | 1 | Phase-advance pulse, one half bit per pulse |
| cfg_wide | input | 1 | Slot width: 0 = 16 bits, 1 = 32 bits |
| cfg_mono | input | 1 | Format: 1 = mono, 0 = stereo |
| s_valid | input | 1 | A sample is offered |
| s_ready | output | 1 | The slot starting now takes a sample |
| s_data | input | 32 | Sample word, right-aligned for 16-bit slots |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 = left, 1 = right) |
| sd | output | 1 | Serial data |

## Verification
Two things can happen in the same cycle: a sample can be accepted at the fall that starts a slot, and that same fall can drive the slot's MSB, toggle `ws` at a slot end, or start an underflow slot. The bench provokes these with back-to-back samples, gaps that span whole frames, and a sample raised in the middle of a left slot, so that it competes with the gated start of the right slot. A scoreboard rebuilds each slot from `sd` at the rising edges of `sck` and compares it with the word and side that the handshakes predict, or with zeros. This finds a sample that was taken at the wrong slot, shifted, or duplicated wrongly.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph_en,
  input  logic              cfg_wide,
  output logic              sck,
  output logic              ws,
  output logic              fall_evt,
  output logic              slot_start,
  output i2s_tx_pkg::side_e slot_side
);
  import i2s_tx_pkg::*;
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic              sck_q, ws_q;
  logic [CNT_W-1:0]  pos_q;
  side_e             side_q;
  logic [CNT_W-1:0]  last_idx;
  logic              at_last;

  // index of the LSB for the configured width
  assign last_idx   = cfg_wide ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1);
  assign at_last    = (pos_q == last_idx);
  assign fall_evt   = ph_en & sck_q;
  assign slot_start = fall_evt & (pos_q == '0);
  assign slot_side  = side_q;
  assign sck        = sck_q;
  assign ws         = ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      ws_q   <= 1'b0;
      pos_q  <= '0;
      side_q <= SIDE_L;
    end else begin
      if (ph_en) sck_q <= ~sck_q;
      if (fall_evt) begin
        if (at_last) begin
          pos_q  <= '0;
          side_q <= side_e'(~side_q);
          ws_q   <= ~side_q;   // announce the next slot together with the LSB
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_tx_feeder.sv
module i2s_tx_feeder #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  i2s_tx_pkg::side_e slot_side,
  input  logic              cfg_mono,
  input  logic              cfg_wide,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic [DATA_W-1:0] load_word
);
  import i2s_tx_pkg::*;

  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] hold_q;
  logic              left_ok_q;
  logic              take;
  logic              is_left;

  generate
    if (NARROW_W < DATA_W) begin : g_align
      assign aligned = cfg_wide ? s_data
                                : {s_data[NARROW_W-1:0], {(DATA_W-NARROW_W){1'b0}}};
    end else begin : g_same
      assign aligned = s_data;
    end
  endgenerate

  assign is_left = (slot_side == SIDE_L);
  assign s_ready = slot_start & (is_left | (~cfg_mono & left_ok_q));
  assign take    = s_ready & s_valid;

  always_comb begin
    if (take)                   load_word = aligned;
    else if (cfg_mono && !is_left) load_word = hold_q;
    else                        load_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      left_ok_q <= 1'b0;
    end else if (slot_start && is_left) begin
      left_ok_q <= take;
      hold_q    <= take ? aligned : '0;
    end
  end
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic              slot_start,
  input  logic [DATA_W-1:0] load_word,
  output logic              sd
);
  logic [DATA_W-1:0] shreg_q;
  logic              sd_q;

  assign sd = sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      sd_q    <= 1'b0;
    end else if (fall_evt) begin
      if (slot_start) begin
        sd_q    <= load_word[DATA_W-1];
        shreg_q <= load_word << 1;
      end else begin
        sd_q    <= shreg_q[DATA_W-1];
        shreg_q <= shreg_q << 1;
      end
    end
  end
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph_en,
  input  logic              cfg_wide,
  input  logic              cfg_mono,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              sck,
  output logic              ws,
  output logic              sd
);
  import i2s_tx_pkg::*;

  logic              fall_evt;
  logic              slot_start;
  side_e             slot_side;
  logic [DATA_W-1:0] load_word;

  i2s_tx_clkgen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .ph_en(ph_en), .cfg_wide(cfg_wide),
    .sck(sck), .ws(ws), .fall_evt(fall_evt), .slot_start(slot_start),
    .slot_side(slot_side)
  );

  i2s_tx_feeder #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_feeder (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_side(slot_side),
    .cfg_mono(cfg_mono), .cfg_wide(cfg_wide), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .load_word(load_word)
  );

  i2s_tx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .slot_start(slot_start),
    .load_word(load_word), .sd(sd)
  );
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic ph_en,
  input logic cfg_mono,
  input logic s_ready,
  input logic sck,
  input logic ws,
  input logic sd
);
  assert_sck_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_en |=> $stable(sck));
  assert_sck_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ph_en |=> !$stable(sck));
  assert_sd_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(sck));
  assert_ws_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(sck));
  assert_ready_at_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (ph_en && sck));
  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);
  assert_mono_left_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mono && s_ready) |-> !ws);
endmodule

bind i2s_tx i2s_tx_checker u_chk (.*);

// File: tb/i2s_tx_bench.sv
module i2s_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PH_DIV     = 3;
  localparam int FRAME_CLKS = 2 * 32 * 2 * PH_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph_en = 1'b0;
  logic        cfg_wide = 1'b1;
  logic        cfg_mono = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, sck, ws, sd;

  int total = 0;
  int bad = 0;
  int div = 0;
  int cyc = 0;
  bit done = 0;
  bit st_side = 0;
  bit [32:0] expq[$];

  i2s_tx u_i2s_tx (
    .clk(clk), .rst_n(rst_n), .ph_en(ph_en), .cfg_wide(cfg_wide),
    .cfg_mono(cfg_mono), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .sck(sck), .ws(ws), .sd(sd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (div == PH_DIV - 1) begin div <= 0; ph_en <= 1'b1; end
    else begin div <= div + 1; ph_en <= 1'b0; end
  end

  task automatic chk(input bit ok, input string req, input logic [32:0] act,
                     input logic [32:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: rebuild slots from the rising edges of sck
  logic        prev_sck = 1'b0;
  bit          started = 0, mside = 0, wsbad = 0, have_rise = 0;
  int          bitidx = 0, last_rise = 0;
  logic [31:0] acc = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      started = 0; mside = 0; wsbad = 0; bitidx = 0; have_rise = 0; acc = '0;
      expq.delete();
    end else if (sck && !prev_sck) begin
      if (have_rise) chk((cyc - last_rise) == 2 * PH_DIV, "R1 bit period",
                         33'(cyc - last_rise), 33'(2 * PH_DIV));
      have_rise = 1; last_rise = cyc;
      if (!started) begin
        started = 1;
        chk(!sd && !ws, "R9 first rise idle", {31'b0, ws, sd}, 33'b0);
      end else begin
        int w;
        w = cfg_wide ? 32 : 16;
        acc = {acc[30:0], sd};
        if (bitidx < w - 1) wsbad |= (ws != mside);
        else                wsbad |= (ws != !mside);
        bitidx++;
        if (bitidx == w) begin
          bit [32:0] e;
          logic [31:0] got;
          got = cfg_wide ? acc : {16'b0, acc[15:0]};
          e = (expq.size() > 0) ? expq.pop_front() : {mside, 32'b0};
          chk(got == e[31:0] && e[32] == mside,
              "R2 R3 R6 R7 R8 slot content/side", {mside, got}, e);
          chk(!wsbad, "R4 ws timing", {32'b0, wsbad}, 33'b0);
          mside = !mside; bitidx = 0; wsbad = 0;
        end
      end
    end
    prev_sck = sck;
  end

  task automatic do_reset(input bit wide, input bit mono);
    rst_n = 1'b0; cfg_wide = wide; cfg_mono = mono; st_side = 0;
    s_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!sck && !ws && !sd && !s_ready, "R9 reset state",
        {29'b0, sck, ws, sd, s_ready}, 33'b0);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [31:0] w);
    logic [31:0] m;
    s_data = w; s_valid = 1'b1;
    do @(negedge clk); while (!s_ready);
    m = cfg_wide ? w : {16'b0, w[15:0]};
    if (cfg_mono) begin
      expq.push_back({1'b0, m});   // R6 duplicate into both slots
      expq.push_back({1'b1, m});
    end else begin
      expq.push_back({st_side, m}); // R7 left then right
      st_side = !st_side;
    end
    @(posedge clk); #1;
    s_valid = 1'b0; s_data = '0;
  endtask

  task automatic drain();
    wait (expq.size() == 0);
    repeat (2 * FRAME_CLKS) @(posedge clk);
  endtask

  initial begin
    // stereo, 32 bit, back to back
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) send(32'h8000_0001 ^ (32'h1234_5678 * (i + 1)));
    drain();
    // stereo, 16 bit, gaps and a late sample inside a left slot (R7 gating)
    do_reset(1'b0, 1'b0);
    send(32'hFFFF_A5C3); send(32'h0000_8001);
    repeat (FRAME_CLKS) @(posedge clk);          // R8 underflow frames
    @(negedge ws); repeat (3) @(posedge sck); #1;
    send(32'h0000_7E81); send(32'h0000_F00F);
    send(32'h0000_0001); send(32'h0000_8000);
    drain();
    // mono, 32 bit, with a gap
    do_reset(1'b1, 1'b1);
    send(32'hDEAD_BEEF); send(32'h0F0F_F0F0);
    repeat (FRAME_CLKS + 50) @(posedge clk);     // R8 mono silence
    send(32'h8000_0000); send(32'h0000_0001);
    drain();
    // mono, 16 bit
    do_reset(1'b0, 1'b1);
    send(32'h1234_C001); send(32'h0000_3FFE); send(32'hAAAA_5555);
    drain();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule